// File: doc/BRIEF.md
# Ping Round-Trip Delay Timer

This block measures how long a packet takes to reach a remote node and come back. When this node transmits a configuration packet, a counter is cleared and starts counting clock cycles. The counter stops on the first self-ID packet that arrives after that, and the value it holds is the round-trip delay in clock periods. The link layer reads this value to tune the bus gap count. A valid flag shows when a frozen measurement is ready. An overflow flag shows when the count ran past its range.

The block also acts as the responder for a remote ping. A received configuration packet with both the R flag and the T flag at zero raises a one-cycle request. That request makes the transmitter send this node's self-ID at once, without the link layer. Serialising packets and building the self-ID content are outside this block. It only sees one strobe per packet, together with the decoded type of the packet.

Packet types on `tx_kind` and `rx_kind` are encoded as follows: 2'b00 other, 2'b01 configuration, 2'b10 self-ID, 2'b11 other.

Top module: `ping_delay_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `ping_count`=0, `ping_valid`=0, `ping_ovf`=0 and `selfid_req`=0.
- R2: A cycle with `tx_done`=1 and `tx_kind`=2'b01 (configuration sent) starts a measurement. After that edge `ping_count`=0, and each later edge without a stop adds one, so N edges after the start edge the count is N.
- R3: The first cycle with `rx_done`=1 and `rx_kind`=2'b10 (self-ID received) during a measurement freezes the count at its value before that edge and sets `ping_valid`=1 after that edge.
- R4: Once frozen, `ping_count` and `ping_valid` do not change on further self-ID packets or any other received packet until the next configuration packet is sent.
- R5: The count saturates at 2^CNT_W-1 and does not wrap. On the first edge where it would pass that value, `ping_ovf` becomes 1, and it stays 1 until the next start.
- R6: A received packet with `rx_kind`=2'b01, `rx_rflag`=0 and `rx_tflag`=0 makes `selfid_req` high for exactly the one cycle after that edge.
- R7: A received configuration packet with `rx_rflag`=1 or `rx_tflag`=1, or a received packet of any other type, leaves `selfid_req` at 0.
- R8: Nothing other than a sent configuration packet starts or clears the timer. This covers sent self-ID or other packets, and received configuration packets.
- R9: A configuration packet sent while a measurement is running restarts it from 0. If a start and a self-ID arrive in the same cycle, the start wins.
- R10: A new start clears `ping_valid` and `ping_ovf` on the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances once per edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_done | input | 1 | One-cycle strobe: this node finished sending a packet |
| tx_kind | input | 2 | Type of the sent packet |
| rx_done | input | 1 | One-cycle strobe: a packet was received |
| rx_kind | input | 2 | Type of the received packet |
| rx_rflag | input | 1 | R flag of the received configuration packet |
| rx_tflag | input | 1 | T flag of the received configuration packet |
| ping_count | output | CNT_W | Measured or running delay in clock cycles |
| ping_valid | output | 1 | The count is frozen and holds a finished measurement |
| ping_ovf | output | 1 | The count saturated during this measurement |
| selfid_req | output | 1 | One-cycle request to send this node's self-ID at once |

## Verification
The assertions check on every cycle:
- the effect of a start on the outputs;
- that a frozen result keeps its value while no start arrives;
- that the overflow flag is only seen with a saturated count and stays set;
- that the responder pulses exactly after an unflagged configuration packet and at no other time.

Only the bench scenarios can show the following:
- that the frozen value equals the exact number of cycles between start and stop;
- that a start wins over a self-ID in the same cycle;
- that received configuration packets never start the timer;
- the saturation after the full count range.

// File: rtl/ping_pkg.sv
package ping_pkg;

    typedef enum logic [1:0] {
        PKT_OTHER  = 2'b00,
        PKT_CONFIG = 2'b01,
        PKT_SELFID = 2'b10,
        PKT_RSVD   = 2'b11
    } pkt_kind_e;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'b00,
        TMR_RUN  = 2'b01,
        TMR_DONE = 2'b10
    } tmr_state_e;

    typedef struct packed {
        logic      strobe;
        pkt_kind_e kind;
        logic      rflag;
        logic      tflag;
    } rx_pkt_t;

    typedef struct packed {
        logic start;
        logic stop;
    } tmr_ev_t;

    function automatic logic is_cfg_sent(logic strobe, pkt_kind_e kind);
        return strobe && (kind == PKT_CONFIG);
    endfunction

    function automatic logic is_selfid_rx(rx_pkt_t p);
        return p.strobe && (p.kind == PKT_SELFID);
    endfunction

    function automatic logic is_ping_request(rx_pkt_t p);
        return p.strobe && (p.kind == PKT_CONFIG) && !p.rflag && !p.tflag;
    endfunction

endpackage

// File: rtl/ping_ctrl.sv
module ping_ctrl
    import ping_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tmr_ev_t ev,
    output logic    clr,
    output logic    inc,
    output logic    done
);
    tmr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (ev.start) begin
            state_d = TMR_RUN;
        end else begin
            case (state_q)
                TMR_RUN:  if (ev.stop) state_d = TMR_DONE;
                TMR_IDLE: state_d = TMR_IDLE;
                TMR_DONE: state_d = TMR_DONE;
                default:  state_d = TMR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= TMR_IDLE;
        else     state_q <= state_d;
    end

    assign clr  = ev.start;
    assign inc  = (state_q == TMR_RUN) && !ev.stop && !ev.start;
    assign done = (state_q == TMR_DONE);

endmodule

// File: rtl/ping_counter.sv
module ping_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;
    logic             ovf_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count_q <= '0;
            ovf_q   <= 1'b0;
        end else if (inc) begin
            if (count_q == CNT_MAX) ovf_q   <= 1'b1;
            else                    count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;
    assign ovf   = ovf_q;

endmodule

// File: rtl/ping_responder.sv
module ping_responder
    import ping_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_pkt_t rx,
    output logic    req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= is_ping_request(rx);
    end

    assign req = req_q;

endmodule

// File: rtl/ping_delay_timer.sv
module ping_delay_timer
    import ping_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_done,
    input  logic [1:0]       tx_kind,
    input  logic             rx_done,
    input  logic [1:0]       rx_kind,
    input  logic             rx_rflag,
    input  logic             rx_tflag,
    output logic [CNT_W-1:0] ping_count,
    output logic             ping_valid,
    output logic             ping_ovf,
    output logic             selfid_req
);
    rx_pkt_t rx_pkt;
    tmr_ev_t ev;
    logic    clr, inc;

    always_comb begin
        rx_pkt.strobe = rx_done;
        rx_pkt.kind   = pkt_kind_e'(rx_kind);
        rx_pkt.rflag  = rx_rflag;
        rx_pkt.tflag  = rx_tflag;
        ev.start      = is_cfg_sent(tx_done, pkt_kind_e'(tx_kind));
        ev.stop       = is_selfid_rx(rx_pkt);
    end

    ping_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .clr  (clr),
        .inc  (inc),
        .done (ping_valid)
    );

    ping_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .inc   (inc),
        .count (ping_count),
        .ovf   (ping_ovf)
    );

    ping_responder u_resp (
        .clk (clk),
        .rst (rst),
        .rx  (rx_pkt),
        .req (selfid_req)
    );

endmodule

// File: rtl/ping_delay_timer_chk.sv
module ping_delay_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_done,
    input logic [1:0]       tx_kind,
    input logic             rx_done,
    input logic [1:0]       rx_kind,
    input logic             rx_rflag,
    input logic             rx_tflag,
    input logic [CNT_W-1:0] ping_count,
    input logic             ping_valid,
    input logic             ping_ovf,
    input logic             selfid_req
);
    logic start_w, ping_w;
    assign start_w = tx_done && (tx_kind == 2'b01);
    assign ping_w  = rx_done && (rx_kind == 2'b01) && !rx_rflag && !rx_tflag;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (ping_count == '0) && !ping_valid && !ping_ovf && !selfid_req);

    p_start_r10: assert property (@(posedge clk) disable iff (rst)
        start_w |=> (ping_count == '0) && !ping_valid && !ping_ovf);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ping_valid && !start_w) |=> ping_valid && $stable(ping_count));

    p_sat_r5: assert property (@(posedge clk) disable iff (rst)
        ping_ovf |-> (ping_count == {CNT_W{1'b1}}));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ping_ovf && !start_w) |=> ping_ovf);

    p_resp_r6: assert property (@(posedge clk) disable iff (rst)
        ping_w |=> selfid_req);

    p_noresp_r7: assert property (@(posedge clk) disable iff (rst)
        !ping_w |=> !selfid_req);

endmodule

bind ping_delay_timer ping_delay_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_done    (tx_done),
    .tx_kind    (tx_kind),
    .rx_done    (rx_done),
    .rx_kind    (rx_kind),
    .rx_rflag   (rx_rflag),
    .rx_tflag   (rx_tflag),
    .ping_count (ping_count),
    .ping_valid (ping_valid),
    .ping_ovf   (ping_ovf),
    .selfid_req (selfid_req)
);

// File: tb/ping_delay_timer_bench.sv
module ping_delay_timer_bench;
    localparam int W   = 16;
    localparam int MAX = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tx_done = 1'b0;
    logic [1:0]   tx_kind = 2'b00;
    logic         rx_done = 1'b0;
    logic [1:0]   rx_kind = 2'b00;
    logic         rx_rflag = 1'b0;
    logic         rx_tflag = 1'b0;
    logic [W-1:0] ping_count;
    logic         ping_valid, ping_ovf, selfid_req;

    int n_checks = 0;
    int n_fail   = 0;
    string cur_tag = "R1";

    // reference model state
    int m_count = 0;
    bit m_run = 0, m_valid = 0, m_ovf = 0, m_req = 0;

    always #2 clk = ~clk;

    ping_delay_timer #(.CNT_W(W)) u_ping_delay_timer (
        .clk(clk), .rst(rst),
        .tx_done(tx_done), .tx_kind(tx_kind),
        .rx_done(rx_done), .rx_kind(rx_kind),
        .rx_rflag(rx_rflag), .rx_tflag(rx_tflag),
        .ping_count(ping_count), .ping_valid(ping_valid),
        .ping_ovf(ping_ovf), .selfid_req(selfid_req)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_count = 0; m_run = 0; m_valid = 0; m_ovf = 0; m_req = 0;
        end else begin
            m_req = rx_done && rx_kind == 2'b01 && !rx_rflag && !rx_tflag;
            if (tx_done && tx_kind == 2'b01) begin
                m_count = 0; m_run = 1; m_valid = 0; m_ovf = 0;
            end else if (m_run && rx_done && rx_kind == 2'b10) begin
                m_run = 0; m_valid = 1;
            end else if (m_run) begin
                if (m_count == MAX) m_ovf = 1;
                else m_count = m_count + 1;
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        chk({cur_tag, " model count"}, int'(ping_count), m_count);
        chk({cur_tag, " model valid"}, int'(ping_valid), int'(m_valid));
        chk({cur_tag, " model ovf"},   int'(ping_ovf),   int'(m_ovf));
        chk({cur_tag, " model req"},   int'(selfid_req), int'(m_req));
    end

    task automatic cyc(bit td, logic [1:0] tk, bit rd, logic [1:0] rk, bit rf, bit tf);
        tx_done = td; tx_kind = tk; rx_done = rd; rx_kind = rk;
        rx_rflag = rf; rx_tflag = tf;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 2'b00, 0, 2'b00, 0, 0);
    endtask

    task automatic start_tx();  cyc(1, 2'b01, 0, 2'b00, 0, 0); endtask
    task automatic selfid_rx(); cyc(0, 2'b00, 1, 2'b10, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL R2 watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 count", int'(ping_count), 0);
        chk("R1 valid", int'(ping_valid), 0);
        chk("R1 ovf",   int'(ping_ovf),   0);
        chk("R1 req",   int'(selfid_req), 0);
        rst = 1'b0;
        idle(2);

        cur_tag = "R8";
        cyc(0, 2'b00, 1, 2'b01, 1, 0);   // received config, R=1
        cyc(1, 2'b10, 0, 2'b00, 0, 0);   // sent self-ID
        cyc(1, 2'b00, 0, 2'b00, 0, 0);   // sent other
        idle(2);
        chk("R8 no start count", int'(ping_count), 0);
        chk("R8 no start valid", int'(ping_valid), 0);

        cur_tag = "R6";
        cyc(0, 2'b00, 1, 2'b01, 0, 0);
        chk("R6 req pulse", int'(selfid_req), 1);
        idle(1);
        chk("R6 req one cycle", int'(selfid_req), 0);
        chk("R8 rx config no start", int'(ping_count), 0);

        cur_tag = "R7";
        cyc(0, 2'b00, 1, 2'b01, 1, 0);
        chk("R7 R=1 no req", int'(selfid_req), 0);
        cyc(0, 2'b00, 1, 2'b01, 0, 1);
        chk("R7 T=1 no req", int'(selfid_req), 0);
        cyc(0, 2'b00, 1, 2'b01, 1, 1);
        chk("R7 R=T=1 no req", int'(selfid_req), 0);
        cyc(0, 2'b00, 1, 2'b00, 0, 0);
        chk("R7 other kind no req", int'(selfid_req), 0);

        cur_tag = "R2";
        start_tx();
        chk("R2 cleared", int'(ping_count), 0);
        idle(10);
        chk("R2 counting", int'(ping_count), 10);
        cur_tag = "R3";
        selfid_rx();
        chk("R3 frozen count", int'(ping_count), 10);
        chk("R3 valid", int'(ping_valid), 1);

        cur_tag = "R4";
        selfid_rx();
        cyc(0, 2'b00, 1, 2'b01, 0, 0);
        idle(5);
        chk("R4 count held", int'(ping_count), 10);
        chk("R4 valid held", int'(ping_valid), 1);

        cur_tag = "R9";
        start_tx();
        chk("R10 valid cleared", int'(ping_valid), 0);
        idle(3);
        cyc(1, 2'b01, 1, 2'b10, 0, 0);   // start and self-ID together
        chk("R9 start wins count", int'(ping_count), 0);
        chk("R9 start wins valid", int'(ping_valid), 0);
        idle(4);
        selfid_rx();
        chk("R9 restart measured", int'(ping_count), 4);

        cur_tag = "R5";
        start_tx();
        idle(MAX);
        chk("R5 at max", int'(ping_count), MAX);
        chk("R5 not yet ovf", int'(ping_ovf), 0);
        idle(1);
        chk("R5 saturated", int'(ping_count), MAX);
        chk("R5 ovf set", int'(ping_ovf), 1);
        idle(3);
        selfid_rx();
        chk("R5 ovf kept at stop", int'(ping_ovf), 1);
        chk("R3 valid after sat", int'(ping_valid), 1);

        cur_tag = "R10";
        start_tx();
        chk("R10 ovf cleared", int'(ping_ovf), 0);
        chk("R10 count cleared", int'(ping_count), 0);
        idle(2);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule